// File: doc/BRIEF.md
# UART Receiver with Interrupt Sources

This block takes in an asynchronous serial line and turns each character frame into a parallel byte. A single-cycle enable, `baud_tick`, pulses at sixteen times the bit rate and paces all sampling. The baud generator that produces it lies outside the block. The line first passes through a synchronizer. A falling edge must then stay low until the middle of the start bit to be accepted. After that, the data bits, an optional parity bit and the stop bit(s) are each sampled at their centre.

A finished character goes into a holding register. That register is offered on a valid/ready output port. `rx_valid` stays high and `rx_data` stays stable until the consumer takes the byte with `rx_ready`. A character that completes while the previous one is still waiting overwrites it and sets an overrun flag. The port never stalls the serial line. Framing, parity, overrun and break conditions are recorded in sticky status bits, which software clears by writing ones. One interrupt request line combines the data-available source, gated by its own enable, with all four error flags.

A frame whose every sample from the first data bit through the last stop bit is 0 is reported as a break, not as a character. After a break the receiver stays quiet until the line returns high.

Top module: `uart_rx_irq`

## Requirements
- R1: While `rst_n` is low, `rx_valid`, `status` and `irq` are all 0. The synchronized line is taken as idle (1).
- R2: A low level seen on a tick arms start detection. If the line reads 1 on any of the next 8 ticks, the receiver drops back to idle and delivers nothing. Otherwise the start bit is accepted on the 8th tick.
- R3: After an accepted start, each following bit is sampled every 16 ticks. Data arrives LSB first. One clock after the tick that samples the last stop bit, `rx_data` holds the byte and `rx_valid` is 1.
- R4: When `par_en` is 1, one parity bit follows the data. With `par_odd`=0 the ones in data plus parity must be even; with `par_odd`=1 they must be odd. A mismatch sets `status[1]`.
- R5: A stop bit sampled as 0 in a frame that is not a break sets `status[0]`, and the byte is still delivered.
- R6: A character that completes while `rx_valid` is 1 and `rx_ready` is 0 sets `status[2]`. The new byte replaces the held one.
- R7: If every sample from the first data bit through the last stop bit is 0, `status[3]` is set. No byte is loaded, and neither `status[0]` nor `status[1]` is set. The receiver then waits for a tick with the line at 1 before it arms again.
- R8: Status bits are `status[0]` framing, `[1]` parity, `[2]` overrun and `[3]` break. Each stays set until a cycle with `clr_we`=1 and the matching `clr_mask` bit at 1. A new event in that same cycle keeps the bit set.
- R9: `irq` = (`rx_valid` AND `data_ie`) OR any status bit. `data_ie` masks only the data source.
- R10: A cycle with `rx_valid` and `rx_ready` both high clears `rx_valid` on the next clock, unless a new character completes in that cycle. This also drops the data source of `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| par_en | input | 1 | Expect a parity bit after the data |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| data_ie | input | 1 | Enable for the data-available interrupt source |
| rx_valid | output | 1 | Held byte is available |
| rx_ready | input | 1 | Consumer takes the held byte this cycle |
| rx_data | output | DATA_BITS | Held received byte |
| clr_we | input | 1 | Write-one-to-clear strobe for the status bits |
| clr_mask | input | 4 | Status bits to clear when `clr_we` is high |
| status | output | 4 | Sticky flags: framing, parity, overrun, break |
| irq | output | 1 | Combined receiver interrupt request |

## Verification
The assertions check on every clock that the interrupt line agrees with the status bits and the data enable. They also check that flags survive any cycle without a clear strobe, that a waiting byte neither disappears nor changes unless an overrun is flagged, and that a newly flagged break never alters the held byte. Four behaviours can only be shown by the bench's scenarios, where a cycle-level reference model follows the serial frames: glitch rejection at mid-start, the LSB-first sampling position, parity in both senses, and re-arming only after the line goes high once a break ends.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int FLAG_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRKW
  } rx_state_e;

  // bit order matches the status port: frm=0, par=1, ovr=2, brk=3
  typedef struct packed {
    logic brk;
    logic ovr;
    logic par;
    logic frm;
  } rx_flags_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] q;

  for (genvar g = 0; g < STAGES; g++) begin : g_st
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[g] <= 1'b1;
        else        q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[g] <= 1'b1;
        else        q[g] <= q[g-1];
      end
    end
  end

  assign dout = q[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16,
  parameter int STOP_BITS = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line,
  input  logic                 par_en,
  input  logic                 par_odd,
  output logic                 done,
  output logic                 done_brk,
  output logic                 done_frm,
  output logic                 done_par,
  output logic [DATA_BITS-1:0] done_data
);

  localparam int CNT_W = $clog2(OVS);
  localparam int HALF  = OVS / 2;
  localparam int IDX_W = $clog2(DATA_BITS + STOP_BITS + 1);

  rx_state_e            state;
  logic [CNT_W-1:0]     cnt;
  logic [IDX_W-1:0]     idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 seen_one;
  logic                 par_bit;
  logic                 stop_bad;
  logic                 bit_pt;
  logic                 brk_now;

  assign bit_pt  = tick && (cnt == CNT_W'(OVS - 1));
  assign brk_now = !seen_one && !line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      seen_one <= 1'b0;
      par_bit  <= 1'b0;
      stop_bad <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (tick && !line) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (line) begin
              state <= ST_IDLE;
            end else if (cnt == CNT_W'(HALF - 1)) begin
              state    <= ST_DATA;
              cnt      <= '0;
              idx      <= '0;
              seen_one <= 1'b0;
              stop_bad <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (bit_pt) begin
            cnt      <= '0;
            shreg    <= {line, shreg[DATA_BITS-1:1]};
            seen_one <= seen_one | line;
            if (idx == IDX_W'(DATA_BITS - 1)) begin
              idx   <= '0;
              state <= par_en ? ST_PAR : ST_STOP;
            end else begin
              idx <= idx + 1'b1;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (bit_pt) begin
            cnt      <= '0;
            par_bit  <= line;
            seen_one <= seen_one | line;
            state    <= ST_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (bit_pt) begin
            cnt <= '0;
            if (idx == IDX_W'(STOP_BITS - 1)) begin
              idx   <= '0;
              state <= brk_now ? ST_BRKW : ST_IDLE;
            end else begin
              idx      <= idx + 1'b1;
              stop_bad <= stop_bad | !line;
              seen_one <= seen_one | line;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_BRKW: begin
          if (tick && line) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // frame outcome, valid in the cycle of the final stop sample
  assign done      = (state == ST_STOP) && bit_pt && (idx == IDX_W'(STOP_BITS - 1));
  assign done_brk  = brk_now;
  assign done_frm  = !brk_now && (stop_bad || !line);
  assign done_par  = par_en && !brk_now && (par_bit != ((^shreg) ^ par_odd));
  assign done_data = shreg;

endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic                 done_brk,
  input  logic                 done_frm,
  input  logic                 done_par,
  input  logic [DATA_BITS-1:0] done_data,
  input  logic                 rd_ready,
  input  logic                 clr_we,
  input  logic [FLAG_W-1:0]    clr_mask,
  input  logic                 data_ie,
  output logic                 rd_valid,
  output logic [DATA_BITS-1:0] rd_data,
  output logic [FLAG_W-1:0]    status,
  output logic                 irq
);

  rx_flags_t   flags;
  rx_flags_t   set_v;
  logic        load;
  logic        take;
  logic [FLAG_W-1:0] clr_v;

  assign load  = done && !done_brk;
  assign take  = rd_valid && rd_ready;
  assign clr_v = clr_we ? clr_mask : '0;

  always_comb begin
    set_v.frm = done && done_frm;
    set_v.par = done && done_par;
    set_v.ovr = load && rd_valid && !rd_ready;
    set_v.brk = done && done_brk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      flags    <= '0;
    end else begin
      if (load) begin
        rd_valid <= 1'b1;
        rd_data  <= done_data;
      end else if (take) begin
        rd_valid <= 1'b0;
      end
      flags <= (flags & ~clr_v) | set_v;
    end
  end

  assign status = flags;
  assign irq    = (rd_valid && data_ie) || (|flags);

endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVS         = 16,
  parameter int STOP_BITS   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 rxd,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic                 data_ie,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [DATA_BITS-1:0] rx_data,
  input  logic                 clr_we,
  input  logic [FLAG_W-1:0]    clr_mask,
  output logic [FLAG_W-1:0]    status,
  output logic                 irq
);

  logic                 line_s;
  logic                 f_done;
  logic                 f_brk;
  logic                 f_frm;
  logic                 f_par;
  logic [DATA_BITS-1:0] f_data;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (line_s)
  );

  uart_rx_frame #(
    .DATA_BITS(DATA_BITS),
    .OVS      (OVS),
    .STOP_BITS(STOP_BITS)
  ) frame_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .line     (line_s),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .done     (f_done),
    .done_brk (f_brk),
    .done_frm (f_frm),
    .done_par (f_par),
    .done_data(f_data)
  );

  uart_rx_flags #(.DATA_BITS(DATA_BITS)) flags_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (f_done),
    .done_brk (f_brk),
    .done_frm (f_frm),
    .done_par (f_par),
    .done_data(f_data),
    .rd_ready (rx_ready),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .data_ie  (data_ie),
    .rd_valid (rx_valid),
    .rd_data  (rx_data),
    .status   (status),
    .irq      (irq)
  );

endmodule

// File: rtl/uart_rx_irq_chk.sv
module uart_rx_irq_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 data_ie,
  input logic                 rx_valid,
  input logic                 rx_ready,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 clr_we,
  input logic [3:0]           status,
  input logic                 irq
);

  AST_FLAG_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 4'd0) |-> irq); // R9

  AST_DATA_SRC_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && data_ie) |-> irq); // R9

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_ie && status == 4'd0) |-> !irq); // R9

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((status & $past(status)) == $past(status))); // R8

  AST_HELD_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid); // R10

  AST_HELD_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> ($stable(rx_data) || status[2])); // R6

  AST_BREAK_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> $stable(rx_data)); // R7

endmodule

bind uart_rx_irq uart_rx_irq_chk #(.DATA_BITS(DATA_BITS)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .data_ie (data_ie),
  .rx_valid(rx_valid),
  .rx_ready(rx_ready),
  .rx_data (rx_data),
  .clr_we  (clr_we),
  .status  (status),
  .irq     (irq)
);

// File: tb/uart_rx_irq_tb_top.sv
module uart_rx_irq_tb_top;

  localparam int TDIV   = 3;            // clocks per baud tick
  localparam int BITCLK = 16 * TDIV;    // clocks per serial bit

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick = 1'b0;
  logic       rxd;
  logic       par_en;
  logic       par_odd;
  logic       data_ie;
  logic       rx_valid;
  logic       rx_ready;
  logic [7:0] rx_data;
  logic       clr_we;
  logic [3:0] clr_mask;
  logic [3:0] status;
  logic       irq;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  run   = 1'b0;
  bit  ended = 1'b0;

  always #5 clk = ~clk;

  uart_rx_irq dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .baud_tick(baud_tick),
    .rxd      (rxd),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .data_ie  (data_ie),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .status   (status),
    .irq      (irq)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic     m_h1, m_h2;
  int       m_mode, m_ph;
  bit       m_bits[$];
  logic     m_rdy;
  logic [7:0] m_data;
  logic [3:0] m_flags;

  always @(posedge clk) begin
    logic line, fin, f_brk, f_frm, f_par, ones;
    logic [7:0] d;
    int need;
    if (!rst_n) begin
      m_h1 = 1'b1; m_h2 = 1'b1; m_mode = 0; m_ph = 0; m_bits.delete();
      m_rdy = 1'b0; m_data = 8'h00; m_flags = 4'h0;
    end else begin
      line = m_h2; fin = 1'b0; f_brk = 1'b0; f_frm = 1'b0; f_par = 1'b0; d = 8'h00;
      need = 8 + (par_en ? 1 : 0) + 1;
      if (baud_tick) begin
        case (m_mode)
          0: if (!line) begin m_mode = 1; m_ph = 0; end
          1: begin
               if (line) m_mode = 0;
               else if (m_ph == 7) begin m_mode = 2; m_ph = 0; m_bits.delete(); end
               else m_ph++;
             end
          2: begin
               if (m_ph == 15) begin
                 m_ph = 0;
                 m_bits.push_back(line);
                 if (m_bits.size() == need) begin
                   fin = 1'b1;
                   ones = 1'b0;
                   foreach (m_bits[k]) ones = ones | m_bits[k];
                   for (int k = 0; k < 8; k++) d[k] = m_bits[k];
                   f_brk = !ones;
                   f_frm = !f_brk && !m_bits[need-1];
                   f_par = par_en && !f_brk && (m_bits[8] != ((^d) ^ par_odd));
                   m_mode = f_brk ? 3 : 0;
                 end
               end else m_ph++;
             end
          3: if (line) m_mode = 0;
          default: m_mode = 0;
        endcase
      end
      begin
        logic [3:0] setv;
        setv = {fin && f_brk, fin && !f_brk && m_rdy && !rx_ready, fin && f_par, fin && f_frm};
        m_flags = (m_flags & ~(clr_we ? clr_mask : 4'h0)) | setv;
      end
      if (fin && !f_brk) begin
        m_rdy = 1'b1; m_data = d;
      end else if (m_rdy && rx_ready) begin
        m_rdy = 1'b0;
      end
      m_h2 = m_h1; m_h1 = rxd;
    end
  end

  // per-cycle comparison, away from the edge
  always begin
    @(posedge clk);
    #2;
    if (rst_n && run && !ended) begin
      chk("R3 rx_valid", rx_valid, m_rdy);
      chk("R3 rx_data", rx_data, m_data);
      chk("R8 status", status, m_flags);
      chk("R9 irq", irq, (m_rdy && data_ie) || (m_flags != 4'h0));
    end
  end

  // baud tick source
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      baud_tick = (c == TDIV - 1);
      c = (c == TDIV - 1) ? 0 : c + 1;
    end
  end

  task automatic hold_bit(input logic b);
    rxd = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic idle(input int nbits);
    repeat (nbits) hold_bit(1'b1);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit with_par,
                            input logic pbit, input logic stopv);
    hold_bit(1'b0);
    for (int k = 0; k < 8; k++) hold_bit(d[k]);
    if (with_par) hold_bit(pbit);
    hold_bit(stopv);
  endtask

  task automatic accept();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk); clr_we = 1'b1; clr_mask = m;
    @(negedge clk); clr_we = 1'b0; clr_mask = 4'h0;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R3 actual=timeout expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; rx_ready = 1'b0; clr_we = 1'b0; clr_mask = 4'h0;
    par_en = 1'b0; par_odd = 1'b0; data_ie = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset rx_valid", rx_valid, 0);
    chk("R1 reset status", status, 0);
    chk("R1 reset irq", irq, 0);
    rst_n = 1'b1;
    run = 1'b1;
    idle(2);

    // plain character, LSB first
    send_frame(8'hA5, 0, 1'b0, 1'b1);
    chk("R3 valid after frame", rx_valid, 1);
    chk("R3 byte", rx_data, 8'hA5);
    chk("R9 data irq", irq, 1);
    accept();
    chk("R10 accept clears valid", rx_valid, 0);
    chk("R10 accept drops irq", irq, 0);
    idle(1);

    // short low pulse: rejected start
    rxd = 1'b0;
    repeat (4 * TDIV) @(negedge clk);
    idle(2);
    chk("R2 glitch no byte", rx_valid, 0);
    chk("R2 glitch no flags", status, 0);

    // masked data source
    data_ie = 1'b0;
    send_frame(8'h5A, 0, 1'b0, 1'b1);
    chk("R9 masked valid", rx_valid, 1);
    chk("R9 masked irq", irq, 0);
    data_ie = 1'b1;
    @(negedge clk);
    chk("R9 unmasked irq", irq, 1);
    accept();
    idle(1);

    // even parity good then bad
    par_en = 1'b1; par_odd = 1'b0;
    send_frame(8'h3C, 1, 1'b0, 1'b1);
    chk("R4 even parity ok", status, 0);
    chk("R4 byte with parity", rx_data, 8'h3C);
    accept();
    idle(1);
    send_frame(8'h3C, 1, 1'b1, 1'b1);
    chk("R4 even parity error", status[1], 1);
    chk("R9 error irq", irq, 1);
    accept();
    chk("R9 irq held by flag", irq, 1);
    clear(4'b0010);
    chk("R8 w1c parity", status, 0);
    idle(1);

    // odd parity good
    par_odd = 1'b1;
    send_frame(8'h07, 1, 1'b0, 1'b1);
    chk("R4 odd parity ok", status, 0);
    accept();
    par_en = 1'b0; par_odd = 1'b0;
    idle(1);

    // framing error
    send_frame(8'h81, 0, 1'b0, 1'b0);
    chk("R5 framing flag", status[0], 1);
    chk("R5 byte still delivered", rx_valid, 1);
    chk("R5 byte value", rx_data, 8'h81);
    idle(3);
    accept();
    clear(4'hF);
    idle(1);

    // overrun
    send_frame(8'h11, 0, 1'b0, 1'b1);
    idle(1);
    send_frame(8'h22, 0, 1'b0, 1'b1);
    chk("R6 overrun flag", status[2], 1);
    chk("R6 newest byte kept", rx_data, 8'h22);
    chk("R6 still valid", rx_valid, 1);
    accept();
    clear(4'hF);
    idle(1);

    // break: line low across the whole frame
    rxd = 1'b0;
    repeat (11 * BITCLK) @(negedge clk);
    chk("R7 break flag", status[3], 1);
    chk("R7 no framing on break", status[0], 0);
    chk("R7 no byte on break", rx_valid, 0);
    idle(2);
    send_frame(8'h6E, 0, 1'b0, 1'b1);
    chk("R7 rearm after break", rx_valid, 1);
    chk("R7 byte after break", rx_data, 8'h6E);
    accept();
    clear(4'b1000);
    chk("R8 w1c break", status, 0);
    idle(2);

    ended = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule